// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one byte-wide general-purpose I/O port with per-line interrupt detection. Each line can be an input or an output. Output lines are driven from a stored data byte. Reads of the data location return the pin levels after synchronization. Every line has its own interrupt detector. A detection-mode bit selects level or edge sensing, and a polarity bit selects high or rising versus low or falling.

Edge events stay latched until software acknowledges them by writing ones to the acknowledge location. Level events follow the input for as long as it sits at the selected level. A per-line enable gates both kinds. The gated pending bits appear as a vector and as a single OR'd port interrupt, and software can read them as a status byte. To sense both edges, software flips the polarity bit after each event. While it rewrites the mode and polarity bits, software holds the line's enable at zero.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, all lines are inputs (pin_oe = 0), pin_out = 0, nothing is pending (irq_line = 0, irq_port = 0) and the status byte reads 0.
- R2: A write to offset 0x10 sets the direction byte. Bit i = 1 makes line i an output (pin_oe[i] = 1) from the next clock, and bit i = 0 makes it an input. The byte reads back at 0x10.
- R3: A write to offset 0x00 sets the byte driven on pin_out. A read of 0x00 returns pin_in after a two-flop synchronizer. bus_rdata is registered and shows the location addressed on the previous clock.
- R4: Offset 0x90 holds the mode byte (bit i: 0 = level, 1 = edge). Offset 0x94 holds the polarity byte (bit i: 0 = low level or falling edge, 1 = high level or rising edge). Both read back.
- R5: A level-mode line that is enabled is pending while its synchronized input equals the selected level, and is no longer pending once the input leaves that level. Acknowledging it has no effect.
- R6: An enabled edge-mode line latches a pending event on the selected edge only. The event stays pending after the input returns.
- R7: Writing a mask to offset 0x98 clears the latched edge events of the lines whose mask bit is 1 and leaves all other lines pending. This location reads 0.
- R8: Offset 0x9C holds the enable byte. A line whose enable bit is 0 reports nothing, and an edge that arrives while it is disabled is not latched. Changing mode or polarity while a line is disabled creates no event when the line is enabled again.
- R9: A read of offset 0xA0 returns the enabled pending bits, with bit i for line i. Writes to 0xA0 change nothing.
- R10: irq_line[i] is the enabled pending bit of line i, and irq_port is the OR of all of them.
- R11: If an edge-mode line's polarity is inverted after an event and the event is acknowledged, the next edge of the opposite direction raises a new event. Inverting the polarity while the input is steady raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output data for the pins |
| pin_oe | output | 8 | Per-line output enable |
| irq_line | output | 8 | Per-line enabled pending |
| irq_port | output | 1 | OR of all enabled pending bits |

## Verification
If a latched edge event is lost or wrongly set, it shows on irq_line and irq_port four clocks after the pin changes. The event then persists until the matching acknowledge, so a missing set or a leaked set is still visible long after the pin has returned. If the acknowledge clears the wrong lines, the fault shows in the following cycle on the neighbouring lines that should stay pending. A wrong polarity or mode bit makes a level line fail to track its pin within three clocks. An enable that leaks shows as an event in the first cycle after the line is enabled again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_MODE,
    SEL_POL,
    SEL_ACK,
    SEL_EN,
    SEL_STAT
  } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= stg[LAST];
  end

  assign sync_o = stg[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int          WIDTH    = 8,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  OFS_DATA = 8'h00,
  parameter logic [7:0]  OFS_DIR  = 8'h10,
  parameter logic [7:0]  OFS_MODE = 8'h90,
  parameter logic [7:0]  OFS_POL  = 8'h94,
  parameter logic [7:0]  OFS_ACK  = 8'h98,
  parameter logic [7:0]  OFS_EN   = 8'h9C,
  parameter logic [7:0]  OFS_STAT = 8'hA0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_lvl_i,
  input  logic [WIDTH-1:0]  status_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  mode_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  ack_o
);

  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
    else if (bus_addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
    else if (bus_addr == ADDR_W'(OFS_MODE)) sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(OFS_POL))  sel = SEL_POL;
    else if (bus_addr == ADDR_W'(OFS_ACK))  sel = SEL_ACK;
    else if (bus_addr == ADDR_W'(OFS_EN))   sel = SEL_EN;
    else if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      dir_o  <= '0;
      mode_o <= '0;
      pol_o  <= '0;
      en_o   <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DATA: data_o <= bus_wdata;
        SEL_DIR:  dir_o  <= bus_wdata;
        SEL_MODE: mode_o <= bus_wdata;
        SEL_POL:  pol_o  <= bus_wdata;
        SEL_EN:   en_o   <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign ack_o = (bus_wr && sel == SEL_ACK) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        SEL_DATA: bus_rdata <= pin_lvl_i;
        SEL_DIR:  bus_rdata <= dir_o;
        SEL_MODE: bus_rdata <= mode_o;
        SEL_POL:  bus_rdata <= pol_o;
        SEL_EN:   bus_rdata <= en_o;
        SEL_STAT: bus_rdata <= status_i;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (dir_o == $past(bus_wdata)));

  p_enable_write_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_EN)) |=> (en_o == $past(bus_wdata)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] ack_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] irq_line_o,
  output logic             irq_port_o
);

  logic [WIDTH-1:0] lat;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic rise, fall, hit, lvl_match;

    assign rise      = sync_i[i] & ~prev_i[i];
    assign fall      = ~sync_i[i] & prev_i[i];
    assign hit       = en_i[i] & mode_i[i] & (pol_i[i] ? rise : fall);
    assign lvl_match = pol_i[i] ? sync_i[i] : ~sync_i[i];

    always_ff @(posedge clk) begin
      if (rst)             lat[i] <= 1'b0;
      else if (!mode_i[i]) lat[i] <= 1'b0;
      else                 lat[i] <= (lat[i] & ~ack_i[i]) | hit;
    end

    assign status_o[i] = en_i[i] & (mode_i[i] ? lat[i] : lvl_match);

    p_no_set_disabled_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(lat[i]) |-> $past(en_i[i]));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (ack_i[i] && !hit) |=> !lat[i]);

    p_level_unlatched_r5: assert property (@(posedge clk) disable iff (rst)
      !mode_i[i] |=> !lat[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line_o <= '0;
      irq_port_o <= 1'b0;
    end else begin
      irq_line_o <= status_o;
      irq_port_o <= |status_o;
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  irq_line,
  output logic              irq_port
);

  logic [WIDTH-1:0] sync_lvl, prev_lvl;
  logic [WIDTH-1:0] mode_r, pol_r, en_r, ack_mask, status;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_in),
    .sync_o  (sync_lvl),
    .prev_o  (prev_lvl)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl_i (sync_lvl),
    .status_i  (status),
    .data_o    (pin_out),
    .dir_o     (pin_oe),
    .mode_o    (mode_r),
    .pol_o     (pol_r),
    .en_o      (en_r),
    .ack_o     (ack_mask)
  );

  gpio_irq_unit #(.WIDTH(WIDTH)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_lvl),
    .prev_i     (prev_lvl),
    .mode_i     (mode_r),
    .pol_i      (pol_r),
    .en_i       (en_r),
    .ack_i      (ack_mask),
    .status_o   (status),
    .irq_line_o (irq_line),
    .irq_port_o (irq_port)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (irq_port == 1'b0 && pin_oe == '0 && pin_out == '0));

  p_port_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq_port == (|irq_line));

  p_line_gated_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!en_r) |-> ((irq_line & ~$past(en_r)) == '0));

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;

  localparam logic [7:0] A_DATA = 8'h00;
  localparam logic [7:0] A_DIR  = 8'h10;
  localparam logic [7:0] A_MODE = 8'h90;
  localparam logic [7:0] A_POL  = 8'h94;
  localparam logic [7:0] A_ACK  = 8'h98;
  localparam logic [7:0] A_EN   = 8'h9C;
  localparam logic [7:0] A_STAT = 8'hA0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, irq_line;
  logic       irq_port;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_line(irq_line), .irq_port(irq_port)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pin_in = '0; bus_wr = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic setup_lines(input logic [7:0] mode, input logic [7:0] pol, input logic [7:0] en);
    wr(A_EN, 8'h00);
    wr(A_MODE, mode);
    wr(A_POL, pol);
    wr(A_EN, en);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq_line", irq_line, 8'h00);
    chk("R1 irq_port", {7'd0, irq_port}, 8'h00);
    rd(A_STAT, d);
    chk("R1 status", d, 8'h00);
  endtask

  task automatic t_dir_data();
    logic [7:0] d;
    do_reset();
    wr(A_DIR, 8'hA5);
    chk("R2 pin_oe", pin_oe, 8'hA5);
    rd(A_DIR, d);
    chk("R2 dir readback", d, 8'hA5);
    wr(A_DIR, 8'h0F);
    chk("R2 dir back to input", pin_oe, 8'h0F);
    wr(A_DATA, 8'h3C);
    chk("R3 pin_out", pin_out, 8'h3C);
    @(negedge clk); pin_in = 8'h96;
    idle(3);
    rd(A_DATA, d);
    chk("R3 pin level read", d, 8'h96);
    wr(A_MODE, 8'h5A);
    wr(A_POL, 8'hC3);
    rd(A_MODE, d);
    chk("R4 mode readback", d, 8'h5A);
    rd(A_POL, d);
    chk("R4 polarity readback", d, 8'hC3);
    rd(A_ACK, d);
    chk("R7 ack reads zero", d, 8'h00);
  endtask

  task automatic t_level();
    do_reset();
    setup_lines(8'h00, 8'h08, 8'h18);
    idle(2);
    chk("R5 low-level line pending at rest", irq_line, 8'h10);
    @(negedge clk); pin_in = 8'h18;
    idle(5);
    chk("R5 high-level pending, low released", irq_line, 8'h08);
    wr(A_ACK, 8'h08);
    idle(2);
    chk("R5 ack ignored by level line", irq_line, 8'h08);
    @(negedge clk); pin_in = 8'h00;
    idle(5);
    chk("R5 level released", irq_line, 8'h10);
    chk("R10 port or", {7'd0, irq_port}, 8'h01);
  endtask

  task automatic t_edge();
    do_reset();
    setup_lines(8'h03, 8'h01, 8'h03);
    idle(2);
    chk("R6 idle no event", irq_line, 8'h00);
    chk("R10 port idle", {7'd0, irq_port}, 8'h00);
    @(negedge clk); pin_in = 8'h03;
    idle(5);
    chk("R6 rising caught, falling-mode line quiet", irq_line, 8'h01);
    chk("R10 port raised", {7'd0, irq_port}, 8'h01);
    @(negedge clk); pin_in = 8'h00;
    idle(5);
    chk("R6 rising held, falling caught", irq_line, 8'h03);
    wr(A_ACK, 8'h03);
    idle(2);
    chk("R7 all acked", irq_line, 8'h00);
    chk("R10 port dropped", {7'd0, irq_port}, 8'h00);
  endtask

  task automatic t_ack_select();
    logic [7:0] d;
    do_reset();
    setup_lines(8'h06, 8'h06, 8'h06);
    @(negedge clk); pin_in = 8'h06;
    idle(5);
    chk("R7 both pending", irq_line, 8'h06);
    wr(A_ACK, 8'h02);
    idle(2);
    chk("R7 only masked line cleared", irq_line, 8'h04);
    rd(A_STAT, d);
    chk("R9 status bit order", d, 8'h04);
    wr(A_STAT, 8'hFF);
    rd(A_STAT, d);
    chk("R9 status write ignored", d, 8'h04);
  endtask

  task automatic t_disable();
    do_reset();
    setup_lines(8'h20, 8'h20, 8'h00);
    @(negedge clk); pin_in = 8'h20;
    idle(5);
    chk("R8 disabled line silent", irq_line, 8'h00);
    wr(A_EN, 8'h20);
    idle(2);
    chk("R8 edge while disabled not latched", irq_line, 8'h00);
    wr(A_EN, 8'h00);
    wr(A_POL, 8'h00);
    wr(A_MODE, 8'h20);
    wr(A_EN, 8'h20);
    idle(2);
    chk("R8 reconfig no spurious event", irq_line, 8'h00);
    wr(A_EN, 8'h00);
    wr(A_MODE, 8'h00);
    wr(A_POL, 8'h20);
    idle(2);
    chk("R8 matching level masked", irq_line, 8'h00);
    wr(A_EN, 8'h20);
    idle(2);
    chk("R8 level shows once enabled", irq_line, 8'h20);
  endtask

  task automatic t_both_edge();
    do_reset();
    setup_lines(8'h40, 8'h40, 8'h40);
    @(negedge clk); pin_in = 8'h40;
    idle(5);
    chk("R11 rising event", irq_line, 8'h40);
    wr(A_POL, 8'h00);
    wr(A_ACK, 8'h40);
    idle(3);
    chk("R11 flip and ack, no event while steady", irq_line, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    idle(5);
    chk("R11 falling event after flip", irq_line, 8'h40);
  endtask

  initial begin
    t_reset();
    t_dir_data();
    t_level();
    t_edge();
    t_ack_select();
    t_disable();
    t_both_edge();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule